// File: doc/BRIEF.md
# Interrupt Request Controller with Write-One-to-Clear Flags

This block gathers up to fourteen request lines from peripherals and produces a single interrupt request for the processor. A rising edge on a request line sets that line's pending flag. The flag stays set until software writes a one to its bit. Each flag is qualified by a per-source enable bit. One master-enable bit then gates the combined request before it reaches the processor.

Software reaches three 16-bit registers through a simple synchronous bus that uses one strobe and one write qualifier. The enable mask sits at offset 0x200, the pending flags at offset 0x202 and the master enable at offset 0x208. Read data is returned one cycle after the strobe. Alongside the request line, the block presents the index of the lowest-numbered source that is both enabled and pending, with a valid bit. A handler can use this index to service sources from the lowest index upward without scanning the flag register.

Top module: `irq_hub`

## Requirements
- R1: After reset the enable mask, the pending flags and the master enable are all zero. `cpu_irq` and `irq_idx_vld` are low, and every register reads as zero.
- R2: A 0-to-1 transition on `src_req[i]`, sampled at a clock edge, sets pending flag bit i at that edge. A request held high does not set the flag again once it has been cleared.
- R3: A write to offset 0x202 clears every flag bit whose data bit is 1. Flag bits whose data bit is 0 keep their value.
- R4: If a rising edge on source i and a write-one-to-clear of flag bit i fall in the same cycle, flag bit i stays set.
- R5: Only bits 13..0 of the enable and flag registers exist. Bits 15..14 always read as zero, and writes to them have no effect.
- R6: Bit 0 of the register at offset 0x208 is the master enable. While it is 0, `cpu_irq` stays low. Bits 15..1 of that register read as zero.
- R7: `cpu_irq` is a register. It is high one cycle after a cycle in which the master enable is 1 and at least one source is both enabled and pending.
- R8: `irq_idx` gives the lowest-numbered source that is both enabled and pending, registered with the same one-cycle delay as `cpu_irq`. `irq_idx_vld` shows that such a source exists, whatever the master enable is set to.
- R9: A read strobe (`bus_sel`=1, `bus_wr`=0) returns the addressed register on `bus_rdata` in the following cycle. Offsets other than 0x200, 0x202 and 0x208 read as zero, and `bus_rdata` is zero in any cycle after one with no read.
- R10: A source whose enable bit is 0 still sets its pending flag on a rising edge, but it does not raise `cpu_irq` or `irq_idx_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 14 | Request lines from the sources |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| cpu_irq | output | 1 | Registered interrupt request to the processor |
| irq_idx | output | 4 | Lowest enabled pending source |
| irq_idx_vld | output | 1 | Some source is enabled and pending |

## Verification
The request lines are driven with single-source pulses, with several sources rising together, and with a request held high across its own clear. The single pulses set the flag-set to request-line latency apart, cycle by cycle. The simultaneous rises show whether the index picks the lowest source and moves to the next one as each flag is cleared. The held request separates edge detection from level sampling. Two further cases are run: a rising edge placed in the same cycle as a clear of that bit, and a pulse on a masked source. These show whether set takes priority over clear, and whether masking hides the request without losing the flag.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_EN   = 2'd1,
        REG_FLAG = 2'd2,
        REG_MEN  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
    import irq_hub_pkg::*;
#(
    parameter int          ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] EN_OFS   = 10'h200,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 10'h202,
    parameter logic [ADDR_W-1:0] MEN_OFS  = 10'h208
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == EN_OFS)        sel = REG_EN;
        else if (addr == FLAG_OFS) sel = REG_FLAG;
        else if (addr == MEN_OFS)  sel = REG_MEN;
        else                       sel = REG_NONE;
    end

endmodule

// File: rtl/irq_hub_flags.sv
module irq_hub_flags #(
    parameter int NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] flag_q
);

    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] flag;
    } flag_st_t;

    flag_st_t           st_d, st_q;
    logic [NUM_SRC-1:0] rise;

    // per-source edge detect; a new edge wins over a clear in the same cycle
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign rise[g] = src_req[g] & ~st_q.prev[g];
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_req;
        st_d.flag = (st_q.flag & ~clr_mask) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q = st_q.flag;

endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
    parameter int NUM_SRC = 14,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] act,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (act[i]) idx = IDX_W'(i);
        end
        any = |act;
    end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC  = 14,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] EN_OFS   = 10'h200,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 10'h202,
    parameter logic [ADDR_W-1:0] MEN_OFS  = 10'h208,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               cpu_irq,
    output logic [IDX_W-1:0]   irq_idx,
    output logic               irq_idx_vld
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic               men;
        logic               irq;
        logic [IDX_W-1:0]   idx;
        logic               vld;
        logic [DATA_W-1:0]  rdata;
    } hub_st_t;

    hub_st_t            st_d, st_q;
    reg_sel_e           sel;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] act;
    logic [IDX_W-1:0]   prio_idx;
    logic               prio_any;
    logic [DATA_W-1:0]  rd_val;
    logic               wr_hit, rd_hit;
    logic               wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-1:NUM_SRC];

    irq_hub_decode #(
        .ADDR_W  (ADDR_W),
        .EN_OFS  (EN_OFS),
        .FLAG_OFS(FLAG_OFS),
        .MEN_OFS (MEN_OFS)
    ) i_decode (
        .addr(bus_addr),
        .sel (sel)
    );

    irq_hub_flags #(
        .NUM_SRC(NUM_SRC)
    ) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_req (src_req),
        .clr_mask(clr_mask),
        .flag_q  (flag_q)
    );

    assign act = st_q.en & flag_q;

    irq_hub_prio #(
        .NUM_SRC(NUM_SRC),
        .IDX_W  (IDX_W)
    ) i_prio (
        .act(act),
        .idx(prio_idx),
        .any(prio_any)
    );

    always_comb begin
        st_d     = st_q;
        wr_hit   = bus_sel & bus_wr;
        rd_hit   = bus_sel & ~bus_wr;
        clr_mask = '0;

        if (wr_hit) begin
            case (sel)
                REG_EN:   st_d.en  = bus_wdata[NUM_SRC-1:0];
                REG_FLAG: clr_mask = bus_wdata[NUM_SRC-1:0];
                REG_MEN:  st_d.men = bus_wdata[0];
                default:  ;
            endcase
        end

        st_d.vld = prio_any;
        st_d.idx = prio_idx;
        st_d.irq = prio_any & st_q.men;

        rd_val = '0;
        case (sel)
            REG_EN:   rd_val[NUM_SRC-1:0] = st_q.en;
            REG_FLAG: rd_val[NUM_SRC-1:0] = flag_q;
            REG_MEN:  rd_val[0]           = st_q.men;
            default:  ;
        endcase
        st_d.rdata = rd_hit ? rd_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata   = st_q.rdata;
    assign cpu_irq     = st_q.irq;
    assign irq_idx     = st_q.idx;
    assign irq_idx_vld = st_q.vld;

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
    parameter int NUM_SRC  = 14,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 10'h202,
    parameter int IDX_W    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_req,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               cpu_irq,
    input logic [IDX_W-1:0]   irq_idx,
    input logic               irq_idx_vld,
    input logic [NUM_SRC-1:0] en_q,
    input logic               men_q,
    input logic [NUM_SRC-1:0] flag_q
);

    logic [NUM_SRC-1:0] src_prev, rise_prev, clr_prev, flag_prev, act_prev;
    logic [NUM_SRC-1:0] clr_now, below;
    logic               irq_cond_prev;

    assign clr_now = (bus_sel && bus_wr && bus_addr == FLAG_OFS)
                   ? bus_wdata[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_prev      <= '0;
            rise_prev     <= '0;
            clr_prev      <= '0;
            flag_prev     <= '0;
            act_prev      <= '0;
            irq_cond_prev <= 1'b0;
        end else begin
            src_prev      <= src_req;
            rise_prev     <= src_req & ~src_prev;
            clr_prev      <= clr_now;
            flag_prev     <= flag_q;
            act_prev      <= en_q & flag_q;
            irq_cond_prev <= men_q && |(en_q & flag_q);
        end
    end

    always_comb begin
        below = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (i < int'(irq_idx)) below[i] = 1'b1;
        end
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_SRC] == '0); // R5

    AST_FLAG_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_prev & ~flag_q) & ~clr_prev) == '0); // R3

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_prev & ~flag_q) == '0); // R4

    AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past(men_q)); // R6

    AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == irq_cond_prev); // R7

    AST_VLD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idx_vld == (|act_prev)); // R8

    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idx_vld |-> (act_prev[irq_idx] && ((act_prev & below) == '0))); // R8

endmodule

bind irq_hub irq_hub_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .FLAG_OFS(FLAG_OFS),
    .IDX_W   (IDX_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cpu_irq    (cpu_irq),
    .irq_idx    (irq_idx),
    .irq_idx_vld(irq_idx_vld),
    .en_q       (st_q.en),
    .men_q      (st_q.men),
    .flag_q     (flag_q)
);

// File: tb/test_irq_hub.sv
module test_irq_hub;

    localparam logic [9:0] A_EN   = 10'h200;
    localparam logic [9:0] A_FLAG = 10'h202;
    localparam logic [9:0] A_MEN  = 10'h208;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] src_req = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cpu_irq;
    logic [3:0]  irq_idx;
    logic        irq_idx_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_hub i_irq_hub (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req    (src_req),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cpu_irq    (cpu_irq),
        .irq_idx    (irq_idx),
        .irq_idx_vld(irq_idx_vld)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic cleanup();
        @(negedge clk);
        src_req = '0;
        bus_write(A_FLAG, 16'hFFFF);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 irq", {15'd0, cpu_irq}, 16'd0);
        chk("R1 vld", {15'd0, irq_idx_vld}, 16'd0);
        bus_read(A_EN, v);   chk("R1 enable", v, 16'h0000);
        bus_read(A_FLAG, v); chk("R1 flags", v, 16'h0000);
        bus_read(A_MEN, v);  chk("R1 master", v, 16'h0000);
    endtask

    task automatic t_latch();
        logic [15:0] v;
        bus_write(A_EN, 16'h3FFF);
        bus_write(A_MEN, 16'h0001);
        @(negedge clk); src_req[3] = 1'b1;
        @(negedge clk);
        chk("R7 irq not yet", {15'd0, cpu_irq}, 16'd0);
        @(negedge clk);
        chk("R7 irq", {15'd0, cpu_irq}, 16'd1);
        chk("R8 idx", {12'd0, irq_idx}, 16'd3);
        chk("R8 vld", {15'd0, irq_idx_vld}, 16'd1);
        bus_read(A_FLAG, v); chk("R2 flag set", v, 16'h0008);
        bus_write(A_FLAG, 16'h0008);
        bus_read(A_FLAG, v); chk("R2 R3 held level no reset", v, 16'h0000);
        @(negedge clk);
        chk("R7 irq drops", {15'd0, cpu_irq}, 16'd0);
        cleanup();
    endtask

    task automatic t_multi();
        logic [15:0] v;
        @(negedge clk); src_req = 14'h1220;
        repeat (2) @(negedge clk);
        bus_read(A_FLAG, v); chk("R2 multi flags", v, 16'h1220);
        chk("R8 lowest idx", {12'd0, irq_idx}, 16'd5);
        bus_write(A_FLAG, 16'h0020);
        @(negedge clk);
        chk("R8 next idx", {12'd0, irq_idx}, 16'd9);
        bus_write(A_FLAG, 16'h0000);
        bus_read(A_FLAG, v); chk("R3 zero write keeps", v, 16'h1200);
    endtask

    task automatic t_master();
        logic [15:0] v;
        bus_write(A_MEN, 16'h0000);
        @(negedge clk);
        chk("R6 master off", {15'd0, cpu_irq}, 16'd0);
        chk("R8 vld w/o master", {15'd0, irq_idx_vld}, 16'd1);
        bus_write(A_MEN, 16'hFFFF);
        bus_read(A_MEN, v); chk("R6 master readback", v, 16'h0001);
        chk("R6 master on", {15'd0, cpu_irq}, 16'd1);
        cleanup();
    endtask

    task automatic t_masked();
        logic [15:0] v;
        bus_write(A_EN, 16'h0000);
        @(negedge clk); src_req[2] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 irq masked", {15'd0, cpu_irq}, 16'd0);
        chk("R10 vld masked", {15'd0, irq_idx_vld}, 16'd0);
        bus_read(A_FLAG, v); chk("R10 flag still set", v, 16'h0004);
    endtask

    task automatic t_upper();
        logic [15:0] v;
        bus_write(A_EN, 16'hFFFF);
        bus_read(A_EN, v); chk("R5 enable upper", v, 16'h3FFF);
        bus_write(A_FLAG, 16'hC000);
        bus_read(A_FLAG, v); chk("R5 flag upper clear", v, 16'h0004);
        cleanup();
    endtask

    task automatic t_collide();
        logic [15:0] v;
        @(negedge clk); src_req[7] = 1'b1;
        @(negedge clk); src_req[7] = 1'b0;
        @(negedge clk);
        src_req[7] = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 16'h0080;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(A_FLAG, v); chk("R4 set beats clear", v, 16'h0080);
        cleanup();
    endtask

    task automatic t_unmapped();
        logic [15:0] v;
        bus_write(A_EN, 16'h1111);
        bus_read(10'h204, v); chk("R9 unmapped 204", v, 16'h0000);
        bus_read(10'h000, v); chk("R9 unmapped 000", v, 16'h0000);
        bus_read(A_EN, v);    chk("R9 read timing", v, 16'h1111);
        @(negedge clk);
        chk("R9 idle zero", bus_rdata, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_multi();
        t_master();
        t_masked();
        t_upper();
        t_collide();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule